// File: doc/BRIEF.md
# Interrupt Acceptance Unit

This block sits next to a processor core and decides, cycle by cycle, whether a pending interrupt is taken. It watches a non-maskable interrupt pin for rising edges. It also takes an encoded 4-bit external level, a set of individual request lines and a set of grouped pin-change request lines; each of those lines has its own priority level, set up elsewhere. It compares every candidate against the interrupt mask held in the status register. When a request is accepted, it produces in one registered cycle all the register writes the core needs for exception entry: the saved return address, the saved status word, the event code written to both event registers, the new status word, and a redirect strobe with the handler address.

Maskable sources are considered only when the core signals an instruction boundary. A latched non-maskable edge is taken as soon as the block bit in the status register is clear. When the block bit is set, every source is held off, the non-maskable one included. On entry the privilege, bank and block bits are forced high. The mask field is left as it was.

Top module: `intr_accept_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `redirect` is 0 and both event code outputs are 0.
- R2: A rising edge on `nmi_pin` is latched. Two clock edges after the rising edge, provided the block bit (status bit 28) is 0, the block raises `redirect` with event code 0x1C0. This happens whatever the mask field holds and whether or not `insn_bnd` is high.
- R3: While status bit 28 is 1, no source is accepted. A non-maskable edge seen during that time stays pending and is taken once bit 28 reads 0, and it is taken only once.
- R4: The encoded level `irl_level` is accepted at a boundary only when it is strictly greater than the mask field (status bits 7:4). Its event code is 0x200 + 0x20 × level.
- R5: Request line i is accepted at a boundary when it is high and its 4-bit priority is strictly greater than the mask. Its code is 0x600 + 0x20 × i. Pin-change group j follows the same rule with code 0x700 + 0x20 × j.
- R6: A pending non-maskable request wins over any maskable request in the same cycle.
- R7: Among the qualifying maskable requests, the highest level wins. Equal levels are resolved in this order: the encoded level first, then the request lines in ascending index, then the pin-change groups in ascending index.
- R8: On acceptance, `spc_wdata` equals the `next_pc` and `ssr_wdata` equals the `sr_in` that were sampled in the accepting cycle.
- R9: On acceptance, `sr_wdata` is the sampled status word with bits 30 (privilege), 29 (bank) and 28 (block) set and all other bits unchanged, mask included. `target_pc` is `vbr` + 0x600.
- R10: No maskable request is accepted while `insn_bnd` is 0. `redirect` is high for exactly one cycle per acceptance, and the outputs are 0 when nothing is accepted.
- R11: `intevt` and `intevt2` always carry the same code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nmi_pin | input | 1 | Non-maskable request, rising-edge sensitive |
| insn_bnd | input | 1 | The core is at an instruction boundary |
| irl_level | input | 4 | Encoded external interrupt level |
| irq_req | input | N_IRQ | Individual request lines |
| irq_prio | input | 4×N_IRQ | Priority for each request line, line i in bits 4i+3:4i |
| pint_req | input | N_PINT | Pin-change group requests |
| pint_prio | input | 4×N_PINT | Priority for each pin-change group |
| sr_in | input | 32 | Current status word |
| vbr | input | ADDR_W | Vector base |
| next_pc | input | ADDR_W | Address of the instruction after the boundary |
| redirect | output | 1 | Acceptance strobe; qualifies every write output |
| target_pc | output | ADDR_W | Handler address |
| spc_wdata | output | ADDR_W | Saved return address |
| ssr_wdata | output | 32 | Saved status word |
| sr_wdata | output | 32 | New status word |
| intevt | output | 12 | Event code, first register |
| intevt2 | output | 12 | Event code, second register |

## Verification
A stuck or lost non-maskable latch shows up within two cycles: either a redirect with code 0x1C0 appears when none is expected, or it is missing once the block bit clears. A mistake in arbitration or code arithmetic shows up in the very next cycle as a wrong `intevt` value. The bench therefore sweeps every level against every mask value, and also runs a long pseudo-random mix of competing sources. A status word that is merged wrongly shows up in `sr_wdata` in the cycle of the strobe.

// File: rtl/intr_accept_pkg.sv
package intr_accept_pkg;
    localparam int SR_W      = 32;
    localparam int MD_BIT    = 30;
    localparam int RB_BIT    = 29;
    localparam int BL_BIT    = 28;
    localparam int IMASK_LSB = 4;
    localparam int LVL_W     = 4;
    localparam int EVT_W     = 12;
    localparam int IDX_W     = 4;

    localparam logic [EVT_W-1:0] EVT_NMI       = 12'h1C0;
    localparam logic [EVT_W-1:0] EVT_IRL_BASE  = 12'h200;
    localparam logic [EVT_W-1:0] EVT_IRQ_BASE  = 12'h600;
    localparam logic [EVT_W-1:0] EVT_PINT_BASE = 12'h700;
    localparam int               VEC_OFS       = 'h600;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_IRL  = 2'd1,
        SRC_IRQ  = 2'd2,
        SRC_PINT = 2'd3
    } src_kind_e;

    typedef struct packed {
        logic             vld;
        src_kind_e        kind;
        logic [IDX_W-1:0] idx;
        logic [LVL_W-1:0] lvl;
    } arb_pick_t;
endpackage

// File: rtl/intr_nmi_latch.sv
module intr_nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_pin,
    input  logic take,
    output logic pend
);
    typedef struct packed {
        logic prev;
        logic pend;
    } nmi_st_t;

    nmi_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = nmi_pin;
        // a fresh edge wins over a clear in the same cycle
        st_d.pend = (st_q.pend & ~take) | (nmi_pin & ~st_q.prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;
endmodule

// File: rtl/intr_level_arb.sv
module intr_level_arb
    import intr_accept_pkg::*;
#(
    parameter int N_IRQ  = 4,
    parameter int N_PINT = 2
) (
    input  logic [LVL_W-1:0]        irl_level,
    input  logic [N_IRQ-1:0]        irq_req,
    input  logic [N_IRQ*LVL_W-1:0]  irq_prio,
    input  logic [N_PINT-1:0]       pint_req,
    input  logic [N_PINT*LVL_W-1:0] pint_prio,
    input  logic [LVL_W-1:0]        imask,
    output arb_pick_t               pick
);
    // fixed scan order gives the tie rule: a later source replaces only on a strictly higher level
    always_comb begin
        pick = '0;
        if (irl_level > imask) begin
            pick.vld  = 1'b1;
            pick.kind = SRC_IRL;
            pick.lvl  = irl_level;
        end
        for (int i = 0; i < N_IRQ; i++) begin
            if (irq_req[i] && (irq_prio[i*LVL_W +: LVL_W] > imask) &&
                (!pick.vld || (irq_prio[i*LVL_W +: LVL_W] > pick.lvl))) begin
                pick.vld  = 1'b1;
                pick.kind = SRC_IRQ;
                pick.idx  = IDX_W'(i);
                pick.lvl  = irq_prio[i*LVL_W +: LVL_W];
            end
        end
        for (int j = 0; j < N_PINT; j++) begin
            if (pint_req[j] && (pint_prio[j*LVL_W +: LVL_W] > imask) &&
                (!pick.vld || (pint_prio[j*LVL_W +: LVL_W] > pick.lvl))) begin
                pick.vld  = 1'b1;
                pick.kind = SRC_PINT;
                pick.idx  = IDX_W'(j);
                pick.lvl  = pint_prio[j*LVL_W +: LVL_W];
            end
        end
    end
endmodule

// File: rtl/intr_evt_encode.sv
module intr_evt_encode
    import intr_accept_pkg::*;
(
    input  arb_pick_t         pick,
    input  logic              nmi_take,
    output logic [EVT_W-1:0]  code
);
    always_comb begin
        code = '0;
        if (nmi_take) begin
            code = EVT_NMI;
        end else if (pick.vld) begin
            unique case (pick.kind)
                SRC_IRL:  code = EVT_IRL_BASE  + {3'b000, pick.lvl, 5'b00000};
                SRC_IRQ:  code = EVT_IRQ_BASE  + {3'b000, pick.idx, 5'b00000};
                SRC_PINT: code = EVT_PINT_BASE + {3'b000, pick.idx, 5'b00000};
                default:  code = '0;
            endcase
        end
    end
endmodule

// File: rtl/intr_accept_unit.sv
module intr_accept_unit
    import intr_accept_pkg::*;
#(
    parameter int N_IRQ  = 4,
    parameter int N_PINT = 2,
    parameter int ADDR_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    nmi_pin,
    input  logic                    insn_bnd,
    input  logic [LVL_W-1:0]        irl_level,
    input  logic [N_IRQ-1:0]        irq_req,
    input  logic [N_IRQ*LVL_W-1:0]  irq_prio,
    input  logic [N_PINT-1:0]       pint_req,
    input  logic [N_PINT*LVL_W-1:0] pint_prio,
    input  logic [SR_W-1:0]         sr_in,
    input  logic [ADDR_W-1:0]       vbr,
    input  logic [ADDR_W-1:0]       next_pc,
    output logic                    redirect,
    output logic [ADDR_W-1:0]       target_pc,
    output logic [ADDR_W-1:0]       spc_wdata,
    output logic [SR_W-1:0]         ssr_wdata,
    output logic [SR_W-1:0]         sr_wdata,
    output logic [EVT_W-1:0]        intevt,
    output logic [EVT_W-1:0]        intevt2
);
    localparam logic [SR_W-1:0] ENTRY_SET =
        (SR_W'(1) << MD_BIT) | (SR_W'(1) << RB_BIT) | (SR_W'(1) << BL_BIT);

    typedef struct packed {
        logic              redirect;
        logic [ADDR_W-1:0] target;
        logic [ADDR_W-1:0] spc;
        logic [SR_W-1:0]   ssr;
        logic [SR_W-1:0]   sr;
        logic [EVT_W-1:0]  evt;
        logic [EVT_W-1:0]  evt2;
    } entry_t;

    entry_t            ent_d, ent_q;
    logic              nmi_pend;
    logic              blocked;
    logic              nmi_take;
    logic              mask_take;
    arb_pick_t         pick;
    logic [EVT_W-1:0]  code;
    logic [LVL_W-1:0]  imask;

    assign imask     = sr_in[IMASK_LSB +: LVL_W];
    assign blocked   = sr_in[BL_BIT];
    assign nmi_take  = nmi_pend & ~blocked;
    assign mask_take = pick.vld & insn_bnd & ~blocked & ~nmi_take;

    intr_nmi_latch u_nmi (
        .clk     (clk),
        .rst_n   (rst_n),
        .nmi_pin (nmi_pin),
        .take    (nmi_take),
        .pend    (nmi_pend)
    );

    intr_level_arb #(
        .N_IRQ  (N_IRQ),
        .N_PINT (N_PINT)
    ) u_arb (
        .irl_level (irl_level),
        .irq_req   (irq_req),
        .irq_prio  (irq_prio),
        .pint_req  (pint_req),
        .pint_prio (pint_prio),
        .imask     (imask),
        .pick      (pick)
    );

    intr_evt_encode u_enc (
        .pick     (pick),
        .nmi_take (nmi_take),
        .code     (code)
    );

    always_comb begin
        ent_d = '0;
        if (nmi_take || mask_take) begin
            ent_d.redirect = 1'b1;
            ent_d.target   = vbr + ADDR_W'(VEC_OFS);
            ent_d.spc      = next_pc;
            ent_d.ssr      = sr_in;
            ent_d.sr       = sr_in | ENTRY_SET;
            ent_d.evt      = code;
            ent_d.evt2     = code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    assign redirect  = ent_q.redirect;
    assign target_pc = ent_q.target;
    assign spc_wdata = ent_q.spc;
    assign ssr_wdata = ent_q.ssr;
    assign sr_wdata  = ent_q.sr;
    assign intevt    = ent_q.evt;
    assign intevt2   = ent_q.evt2;
endmodule

// File: rtl/intr_accept_chk.sv
module intr_accept_chk
    import intr_accept_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              insn_bnd,
    input logic              nmi_pend,
    input logic [SR_W-1:0]   sr_in,
    input logic [ADDR_W-1:0] vbr,
    input logic [ADDR_W-1:0] next_pc,
    input logic              redirect,
    input logic [ADDR_W-1:0] target_pc,
    input logic [ADDR_W-1:0] spc_wdata,
    input logic [SR_W-1:0]   ssr_wdata,
    input logic [SR_W-1:0]   sr_wdata,
    input logic [EVT_W-1:0]  intevt
);
    a_r3_block_all: assert property (@(posedge clk) disable iff (!rst_n)
        sr_in[BL_BIT] |=> !redirect);

    a_r10_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!insn_bnd && !nmi_pend) |=> !redirect);

    a_r2_nmi_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_pend && !sr_in[BL_BIT]) |=> (redirect && intevt == EVT_NMI));

    a_r8_saved_state: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> (spc_wdata == $past(next_pc) && ssr_wdata == $past(sr_in)));

    a_r9_sr_merge: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> (sr_wdata[MD_BIT] && sr_wdata[RB_BIT] && sr_wdata[BL_BIT] &&
                      sr_wdata[IMASK_LSB +: LVL_W] == $past(sr_in[IMASK_LSB +: LVL_W])));

    a_r9_vector: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> (target_pc == $past(vbr) + ADDR_W'(VEC_OFS)));

    a_r4_irl_above_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && intevt >= EVT_IRL_BASE && intevt < 12'h400)
            |-> (intevt[8:5] > $past(sr_in[IMASK_LSB +: LVL_W])));
endmodule

bind intr_accept_unit intr_accept_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .insn_bnd  (insn_bnd),
    .nmi_pend  (nmi_pend),
    .sr_in     (sr_in),
    .vbr       (vbr),
    .next_pc   (next_pc),
    .redirect  (redirect),
    .target_pc (target_pc),
    .spc_wdata (spc_wdata),
    .ssr_wdata (ssr_wdata),
    .sr_wdata  (sr_wdata),
    .intevt    (intevt)
);

// File: tb/tb_intr_accept_unit.sv
module tb_intr_accept_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NI = 2;
    localparam int NP = 1;
    localparam logic [31:0] ENTRY = 32'h7000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nmi_pin = 1'b0, insn_bnd = 1'b0;
    logic [3:0] irl_level = '0;
    logic [NI-1:0] irq_req = '0;
    logic [NI*4-1:0] irq_prio = '0;
    logic [NP-1:0] pint_req = '0;
    logic [NP*4-1:0] pint_prio = '0;
    logic [31:0] sr_in = '0, vbr = '0, next_pc = '0;
    logic redirect;
    logic [31:0] target_pc, spc_wdata, ssr_wdata, sr_wdata;
    logic [11:0] intevt, intevt2;
    int total = 0, bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intr_accept_unit #(.N_IRQ(NI), .N_PINT(NP), .ADDR_W(32)) dut (
        .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .insn_bnd(insn_bnd),
        .irl_level(irl_level), .irq_req(irq_req), .irq_prio(irq_prio),
        .pint_req(pint_req), .pint_prio(pint_prio), .sr_in(sr_in), .vbr(vbr),
        .next_pc(next_pc), .redirect(redirect), .target_pc(target_pc),
        .spc_wdata(spc_wdata), .ssr_wdata(ssr_wdata), .sr_wdata(sr_wdata),
        .intevt(intevt), .intevt2(intevt2));

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] mk_sr(input logic [3:0] m, input bit bl, input logic [31:0] junk);
        logic [31:0] s;
        s = junk & ~(ENTRY | 32'h0000_00F0);
        s[7:4] = m;
        s[28] = bl;
        return s;
    endfunction

    // expected winner by the written rules: {found, code}
    function automatic logic [12:0] ref_code(input logic [3:0] irl, input logic [NI-1:0] rq,
            input logic [NI*4-1:0] rp, input logic [NP-1:0] pr, input logic [NP*4-1:0] pp,
            input logic [3:0] m);
        bit found = 0;
        logic [3:0] best = 0;
        logic [11:0] c = 0;
        if (irl > m) begin found = 1; best = irl; c = 12'h200 + 12'(irl) * 12'h20; end
        for (int i = 0; i < NI; i++)
            if (rq[i] && rp[i*4 +: 4] > m && (!found || rp[i*4 +: 4] > best)) begin
                found = 1; best = rp[i*4 +: 4]; c = 12'h600 + 12'(i) * 12'h20;
            end
        for (int j = 0; j < NP; j++)
            if (pr[j] && pp[j*4 +: 4] > m && (!found || pp[j*4 +: 4] > best)) begin
                found = 1; best = pp[j*4 +: 4]; c = 12'h700 + 12'(j) * 12'h20;
            end
        return {found, c};
    endfunction

    task automatic expect_out(input string tag, input bit er, input logic [11:0] ec,
                              input logic [31:0] s0, input logic [31:0] v0, input logic [31:0] p0);
        chk(redirect == er, {tag, " redirect"}, 32'(redirect), 32'(er));
        if (er) begin
            chk(intevt == ec, {tag, " code"}, 32'(intevt), 32'(ec));
            chk(intevt2 == ec, {tag, " R11 second code"}, 32'(intevt2), 32'(ec));
            chk(spc_wdata == p0, {tag, " R8 spc"}, spc_wdata, p0);
            chk(ssr_wdata == s0, {tag, " R8 ssr"}, ssr_wdata, s0);
            chk(sr_wdata == (s0 | ENTRY), {tag, " R9 sr"}, sr_wdata, s0 | ENTRY);
            chk(target_pc == v0 + 32'h600, {tag, " R9 target"}, target_pc, v0 + 32'h600);
        end else begin
            chk(intevt == 0 && intevt2 == 0, {tag, " R10 idle code"}, 32'(intevt), 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL R10 watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r = 32'h1234_5678;
        logic [31:0] s, v, p;
        logic [12:0] e;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(redirect == 0 && intevt == 0, "R1 in reset", 32'(redirect), 0);
        sr_in = mk_sr(4'hF, 1'b1, 0);
        rst_n = 1'b1;
        step();
        chk(redirect == 0 && intevt == 0 && intevt2 == 0, "R1 after reset", 32'(intevt), 0);

        // R4 / R3: level against mask, block bit on and off
        for (int lvl = 0; lvl < 16; lvl++)
            for (int m = 0; m < 16; m++)
                for (int bl = 0; bl < 2; bl++) begin
                    s = mk_sr(4'(m), bl[0], 32'hA5A5_0F0F ^ (32'(lvl) << 16));
                    v = 32'h0010_0000 * 32'(m + 1);
                    p = 32'h8000_0000 + 32'(lvl * 64 + m * 4);
                    irl_level = 4'(lvl); sr_in = s; vbr = v; next_pc = p; insn_bnd = 1'b1;
                    step();
                    expect_out(bl ? "R3 blocked level" : "R4 level sweep",
                               (bl == 0) && (lvl > m), 12'h200 + 12'(lvl) * 12'h20, s, v, p);
                end

        // R10: no boundary, no maskable acceptance
        irl_level = 4'hF; irq_req = '1; irq_prio = '1; sr_in = mk_sr(0, 0, 0); insn_bnd = 1'b0;
        step();
        expect_out("R10 no boundary", 0, 0, 0, 0, 0);
        irl_level = 0; irq_req = 0; irq_prio = 0;

        // R5 / R7: directed ties and orders
        insn_bnd = 1'b1; sr_in = mk_sr(4'd2, 0, 0); vbr = 32'h4000; next_pc = 32'h100;
        irl_level = 4'd5; irq_req = 2'b01; irq_prio = {4'd0, 4'd5};
        step();
        expect_out("R7 tie level first", 1, 12'h2A0, sr_in, vbr, next_pc);
        irl_level = 0; irq_req = 2'b11; irq_prio = {4'd7, 4'd7};
        step();
        expect_out("R7 tie low index", 1, 12'h600, sr_in, vbr, next_pc);
        irq_req = 2'b10; irq_prio = {4'd3, 4'd9};
        step();
        expect_out("R5 line one", 1, 12'h620, sr_in, vbr, next_pc);
        pint_req = 1'b1; pint_prio = 4'd9; irq_prio = {4'd8, 4'd0};
        step();
        expect_out("R5 pin group higher", 1, 12'h700, sr_in, vbr, next_pc);
        pint_prio = 4'd2; irq_req = 0;
        step();
        expect_out("R5 pin group equal mask", 0, 0, 0, 0, 0);
        pint_req = 0; pint_prio = 0;

        // R2: edge with full mask and no boundary
        insn_bnd = 1'b0; sr_in = mk_sr(4'hF, 0, 32'h0000_0003); vbr = 32'h9000; next_pc = 32'h2220;
        nmi_pin = 1'b1;
        step();
        expect_out("R2 edge latency", 0, 0, 0, 0, 0);
        step();
        expect_out("R2 nmi taken", 1, 12'h1C0, sr_in, vbr, next_pc);
        step();
        expect_out("R3 nmi once", 0, 0, 0, 0, 0);
        nmi_pin = 1'b0;
        step();

        // R3: edge while blocked stays pending
        sr_in = mk_sr(4'h0, 1, 0);
        nmi_pin = 1'b1;
        step();
        nmi_pin = 1'b0;
        for (int k = 0; k < 4; k++) begin
            step();
            expect_out("R3 nmi held off", 0, 0, 0, 0, 0);
        end
        sr_in = mk_sr(4'h3, 0, 32'h0000_1000); next_pc = 32'h3330;
        step();
        expect_out("R3 nmi after unblock", 1, 12'h1C0, sr_in, vbr, next_pc);
        step();
        expect_out("R3 nmi cleared", 0, 0, 0, 0, 0);

        // R6: nmi beats level 15
        sr_in = mk_sr(0, 0, 0); irl_level = 4'hF; insn_bnd = 1'b0; nmi_pin = 1'b1;
        step();
        insn_bnd = 1'b1;
        step();
        expect_out("R6 nmi over level", 1, 12'h1C0, sr_in, vbr, next_pc);
        step();
        expect_out("R6 level after nmi", 1, 12'h3E0, sr_in, vbr, next_pc);
        nmi_pin = 1'b0; irl_level = 0; insn_bnd = 0;
        step();

        // R7 / R5 / R10: pseudo-random competition sweep
        for (int n = 0; n < 3000; n++) begin
            r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
            irl_level = r[3:0]; irq_req = r[5:4]; irq_prio = r[13:6];
            pint_req = r[14]; pint_prio = r[18:15];
            insn_bnd = r[23] | r[24];
            s = mk_sr(r[22:19], r[27:25] == 0, r ^ 32'h5A5A_5A5A);
            v = {r[31:16], 16'h0}; p = {r[15:0], r[31:16]};
            sr_in = s; vbr = v; next_pc = p;
            e = ref_code(r[3:0], r[5:4], r[13:6], r[14], r[18:15], r[22:19]);
            step();
            expect_out("R7 random mix", e[12] && insn_bnd && !s[28], e[11:0], s, v, p);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule